// File: doc/BRIEF.md
# Integer Execute Unit with Opcode Decode

This block is the combinational execute stage of a 32-bit load/store processor. Each cycle it receives the fetched instruction word and the values already read for its two source registers. It decodes the major opcode and, for register-format words, the function code. It then chooses the second ALU operand: either the second register value, or the 16-bit immediate widened to the datapath width. It returns the computed value, the number of the destination register, and a write enable for the register file.

Register-format words support add, subtract and bitwise OR. Immediate-format words support add with a sign-extended immediate and AND with a zero-extended immediate. Any other encoding raises an illegal-instruction flag and suppresses the register write. In that case the result and destination outputs are forced to zero, so nothing downstream can act on a stale value.

Arithmetic wraps at the datapath width and never traps. The surrounding pipeline owns the register file, memory access, the program counter and any exceptions.

Top module: `int_exec_alu`

## Requirements
- R1: The instruction word is decoded with the opcode in bits 31:26, the first source field in 25:21, the second source field in 20:16, the destination field in 15:11, the shift amount in 10:6 and the function code in 5:0. Register-format operations (opcode 0) write to the register named in bits 15:11.
- R2: Opcode 0 with function code 0x21 produces `rs_val + rt_val`, modulo 2^32, with no overflow indication.
- R3: Opcode 0 with function code 0x23 produces `rs_val - rt_val`, modulo 2^32, with no overflow indication.
- R4: Opcode 0 with function code 0x25 produces the bitwise OR of `rs_val` and `rt_val`.
- R5: Opcode 8 produces `rs_val` plus the immediate in bits 15:0. The immediate is sign-extended by copying bit 15 into bits 31:16. The destination is the register in bits 20:16.
- R6: Opcode 12 produces `rs_val` AND the immediate zero-extended to 32 bits, so result bits 31:16 are always 0. The destination is the register in bits 20:16.
- R7: Any other opcode, or opcode 0 with any other function code, drives `illegal` to 1 and `reg_write` to 0. In that case `result` and `dest_reg` are both 0.
- R8: A register-format word with a nonzero shift-amount field (bits 10:6) is treated as illegal, as in R7.
- R9: For every supported encoding, `reg_write` is 1 and `illegal` is 0, in the same evaluation as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| result | output | 32 | Computed value, or 0 when illegal |
| dest_reg | output | 5 | Register number to be written, or 0 when illegal |
| reg_write | output | 1 | Write enable for the register file |
| illegal | output | 1 | Unsupported encoding detected |

## Verification
The embedded checks apply on every evaluation of the inputs and cover the following:
- The write enable and the illegal flag always disagree.
- An illegal word always yields zeroed outputs.
- Subtraction and addition invert each other modulo 2^32.
- An OR result covers both operands.
- The zero-extended AND never sets the upper half.

The bench's scenarios are needed for the remaining behaviour:
- It shows that the destination field switches between bits 15:11 and 20:16 by format.
- It shows that the immediate add sign-extends at the 0x7FFF/0x8000 boundary.
- It shows that neighbouring function codes and opcodes, and nonzero shift amounts, fall into the illegal path.

// File: rtl/int_exec_alu.sv
module int_exec_alu #(
  parameter int XLEN = 32,
  parameter int IMM_W = 16
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [XLEN-1:0] result,
  output logic [4:0]      dest_reg,
  output logic            reg_write,
  output logic            illegal
);
  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_ANDI = 6'd12;
  localparam logic [5:0] FN_ADD  = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h23;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam int EXT_W = XLEN - IMM_W;

  typedef enum logic [2:0] {K_NONE, K_ADD, K_SUB, K_OR, K_ADDI, K_ANDI} kind_t;

  logic [5:0]       op_f, fn_f;
  logic [4:0]       rs_f, rt_f, rd_f, sh_f;
  logic [IMM_W-1:0] imm_f;
  logic [XLEN-1:0]  imm_sx, imm_zx, opb;
  kind_t            kind;

  assign op_f  = instr[31:26];
  assign rs_f  = instr[25:21];
  assign rt_f  = instr[20:16];
  assign rd_f  = instr[15:11];
  assign sh_f  = instr[10:6];
  assign fn_f  = instr[5:0];
  assign imm_f = instr[IMM_W-1:0];

  assign imm_sx = {{EXT_W{imm_f[IMM_W-1]}}, imm_f};
  assign imm_zx = {{EXT_W{1'b0}}, imm_f};

  always_comb begin
    kind = K_NONE;
    unique case (op_f)
      OP_REG: begin
        if (sh_f == 5'd0) begin
          case (fn_f)
            FN_ADD:  kind = K_ADD;
            FN_SUB:  kind = K_SUB;
            FN_OR:   kind = K_OR;
            default: kind = K_NONE;
          endcase
        end
      end
      OP_ADDI: kind = K_ADDI;
      OP_ANDI: kind = K_ANDI;
      default: kind = K_NONE;
    endcase
  end

  always_comb begin
    case (kind)
      K_ADDI:  opb = imm_sx;
      K_ANDI:  opb = imm_zx;
      default: opb = rt_val;
    endcase
  end

  always_comb begin
    case (kind)
      K_ADD, K_ADDI: result = rs_val + opb;
      K_SUB:         result = rs_val - opb;
      K_OR:          result = rs_val | opb;
      K_ANDI:        result = rs_val & opb;
      default:       result = '0;
    endcase
  end

  always_comb begin
    case (kind)
      K_ADD, K_SUB, K_OR: dest_reg = rd_f;
      K_ADDI, K_ANDI:     dest_reg = rt_f;
      default:            dest_reg = 5'd0;
    endcase
  end

  assign illegal   = (kind == K_NONE);
  assign reg_write = (kind != K_NONE);

  always_comb begin
    // R9
    enable_vs_flag_chk: assert (reg_write != illegal);
    // R7
    illegal_zero_chk: assert (!illegal || (result == '0 && dest_reg == 5'd0 && !reg_write));
    // R3
    sub_inverse_chk: assert (!(op_f == OP_REG && fn_f == FN_SUB && sh_f == 5'd0) || (result + rt_val == rs_val));
    // R2
    add_inverse_chk: assert (!(op_f == OP_REG && fn_f == FN_ADD && sh_f == 5'd0) || (result - rt_val == rs_val));
    // R4
    or_cover_chk: assert (!(op_f == OP_REG && fn_f == FN_OR && sh_f == 5'd0) || ((result & rs_val) == rs_val && (result & rt_val) == rt_val));
    // R6
    andi_upper_chk: assert (!(op_f == OP_ANDI) || (result[XLEN-1:IMM_W] == '0 && (result | rs_val) == rs_val));
    // R1
    src_field_chk: assert (!reg_write || !$isunknown(rs_f));
  end
endmodule

// File: tb/sim_int_exec_alu.sv
module sim_int_exec_alu;
  logic        clk = 1'b0;
  logic [31:0] instr, rs_val, rt_val, result;
  logic [4:0]  dest_reg;
  logic        reg_write, illegal;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  int_exec_alu u0 (.instr(instr), .rs_val(rs_val), .rt_val(rt_val),
                   .result(result), .dest_reg(dest_reg),
                   .reg_write(reg_write), .illegal(illegal));

  function automatic logic [39:0] model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic [5:0] op, fn;
    logic [31:0] r;
    logic [4:0] d;
    logic ok;
    op = w[31:26]; fn = w[5:0];
    r = 32'd0; d = 5'd0; ok = 1'b0;
    if (op == 6'd0 && w[10:6] == 5'd0) begin
      if (fn == 6'h21) begin r = a + b; ok = 1'b1; end
      else if (fn == 6'h23) begin r = a - b; ok = 1'b1; end
      else if (fn == 6'h25) begin r = a | b; ok = 1'b1; end
      if (ok) d = w[15:11];
    end else if (op == 6'd8) begin
      r = a + {{16{w[15]}}, w[15:0]}; d = w[20:16]; ok = 1'b1;
    end else if (op == 6'd12) begin
      r = a & {16'd0, w[15:0]}; d = w[20:16]; ok = 1'b1;
    end
    return {ok, ~ok, 1'b0, d, r};
  endfunction

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [39:0] e;
    @(negedge clk);
    instr = w; rs_val = a; rt_val = b;
    #2;
    e = model(w, a, b);
    vectors++;
    if (result !== e[31:0] || dest_reg !== e[36:32] || illegal !== e[38] || reg_write !== e[39]) begin
      fails++;
      $display("FAIL %s instr=%h got res=%h dst=%0d we=%b ill=%b exp res=%h dst=%0d we=%b ill=%b",
               req, w, result, dest_reg, reg_write, illegal, e[31:0], e[36:32], e[39], e[38]);
    end
  endtask

  function automatic logic [31:0] rword(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] sh);
    return {6'd0, 5'd3, 5'd4, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iword(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] imm);
    return {op, 5'd2, rt, imm};
  endfunction

  initial begin
    instr = 32'd0; rs_val = 32'd0; rt_val = 32'd0;
    #2;
    vectors++;
    if (illegal !== 1'b1 || reg_write !== 1'b0 || result !== 32'd0) begin
      fails++;
      $display("FAIL R7 initial word 0 got ill=%b we=%b res=%h exp ill=1 we=0 res=0", illegal, reg_write, result);
    end
    // R1 R2: destination from bits 15:11, wrapping add
    apply(rword(6'h21, 5'd17, 5'd0), 32'hFFFF_FFFF, 32'd1, "R2");
    apply(rword(6'h21, 5'd31, 5'd0), 32'h7FFF_FFFF, 32'd1, "R1");
    // R3 wrap below zero
    apply(rword(6'h23, 5'd5, 5'd0), 32'd0, 32'd1, "R3");
    apply(rword(6'h23, 5'd9, 5'd0), 32'h8000_0000, 32'h7FFF_FFFF, "R3");
    // R4
    apply(rword(6'h25, 5'd1, 5'd0), 32'hF0F0_0000, 32'h0000_0F0F, "R4");
    // R5 sign extension boundary, destination bits 20:16
    apply(iword(6'd8, 5'd12, 16'h7FFF), 32'd1, 32'hDEAD_BEEF, "R5");
    apply(iword(6'd8, 5'd13, 16'h8000), 32'd0, 32'd0, "R5");
    apply(iword(6'd8, 5'd14, 16'hFFFF), 32'd0, 32'd0, "R5");
    // R6 zero extension
    apply(iword(6'd12, 5'd20, 16'hFFFF), 32'hFFFF_FFFF, 32'd0, "R6");
    apply(iword(6'd12, 5'd21, 16'h8001), 32'h1234_8765, 32'd0, "R6");
    // R7 neighbouring codes
    apply(rword(6'h20, 5'd7, 5'd0), 32'd5, 32'd6, "R7");
    apply(rword(6'h24, 5'd7, 5'd0), 32'd5, 32'd6, "R7");
    apply(iword(6'd9, 5'd8, 16'h0001), 32'd5, 32'd6, "R7");
    apply(iword(6'd13, 5'd8, 16'h0001), 32'd5, 32'd6, "R7");
    // R8 shift amount nonzero
    apply(rword(6'h21, 5'd7, 5'd1), 32'd5, 32'd6, "R8");
    apply(rword(6'h25, 5'd7, 5'd16), 32'd5, 32'd6, "R8");
    // R9 random mix
    void'($urandom(32'd7));
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] w;
      int pick;
      w = $urandom;
      pick = $urandom_range(0, 7);
      case (pick)
        0: w[31:26] = 6'd8;
        1: w[31:26] = 6'd12;
        2, 3, 4: begin
          w[31:26] = 6'd0;
          if ($urandom_range(0, 3) != 0) w[10:6] = 5'd0;
          case ($urandom_range(0, 3))
            0: w[5:0] = 6'h21;
            1: w[5:0] = 6'h23;
            2: w[5:0] = 6'h25;
            default: ;
          endcase
        end
        default: ;
      endcase
      apply(w, $urandom, $urandom, "R9");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got no finish exp finish");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule